// File: doc/BRIEF.md
# GF(2) Polynomial Long Divider

This block divides one binary polynomial by another, with coefficients in GF(2). A polynomial is a bit vector in which bit i is the coefficient of x^i. A single start strobe loads a dividend and a divisor. The block then returns the quotient and the remainder together at the end of the same run.

Each busy cycle finds the degree of the partial remainder and the degree of the divisor with a highest-set-bit search. If the remainder's degree is not lower than the divisor's degree, the block shifts the divisor left by the difference and XORs it into the remainder. It also sets the quotient bit at that difference. Because each step jumps by the whole degree difference, one cycle removes one quotient term. The run therefore takes as many reduction cycles as the quotient has set bits, plus one closing cycle.

Top module: `gf2_poly_div`

## Requirements
- R1: After reset, busy, done, div_err, quotient and remainder are all zero.
- R2: A start while busy is low loads the operands, and busy is high from the next cycle.
- R3: In each busy cycle where the partial remainder is nonzero and its degree is at least the divisor degree d, the block XORs in the divisor shifted left by (remainder degree − d) and sets quotient bit (remainder degree − d), so the remainder degree strictly falls.
- R4: For a nonzero divisor, the final results satisfy quotient·divisor XOR remainder = dividend (carry-less product), and the remainder is zero or of lower degree than the divisor.
- R5: Busy stays high for exactly (number of set quotient bits + 1) cycles. A dividend of lower degree than the divisor, or a zero dividend, finishes after one busy cycle with quotient 0 and remainder equal to the dividend.
- R6: A zero divisor makes the run finish after one busy cycle with div_err = 1, quotient 0 and remainder equal to the dividend. div_err is 0 after any run with a nonzero divisor.
- R7: done is a one-cycle pulse. It rises in the same cycle that busy falls.
- R8: After done, quotient, remainder and div_err hold their values until the next accepted start.
- R9: A start that arrives while busy is high is ignored. The running division completes with its original operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division (taken only when idle) |
| dividend | input | W | Dividend polynomial, bit i = coefficient of x^i |
| divisor | input | W | Divisor polynomial |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Last run had a zero divisor |
| quotient | output | W | Quotient polynomial |
| remainder | output | W | Remainder polynomial (partial remainder while busy) |

## Verification
The hardest case to reach from the ports is a second start that arrives while a long run is still reducing. The bench sets a dividend of full degree W−1 and divisor 1, which gives the most reduction cycles. It then pulses start with different operands in the middle of that run. The final results and the busy-cycle count must still match the first operands. Random operand pairs exercise the cycle count against the quotient's set-bit count, and the bench checks both quotient and remainder against an independent bitwise long division and a carry-less product.

// File: rtl/gf2_poly_div.sv
module gf2_poly_div #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         div_err,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int IW = $clog2(W) + 1;

  function automatic logic [IW-1:0] top_one(input logic [W-1:0] v);
    top_one = '0;
    for (int i = 0; i < W; i++)
      if (v[i]) top_one = IW'(i);
  endfunction

  logic [W-1:0]  dsr;
  logic [IW-1:0] rdeg, ddeg, shift;
  logic          rzero, dzero, reduce;

  assign rdeg   = top_one(remainder);
  assign ddeg   = top_one(dsr);
  assign rzero  = ~|remainder;
  assign dzero  = ~|dsr;
  assign reduce = !rzero && !dzero && (rdeg >= ddeg);
  assign shift  = rdeg - ddeg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      div_err   <= 1'b0;
      dsr       <= '0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        remainder <= dividend;
        dsr       <= divisor;
        quotient  <= '0;
        div_err   <= 1'b0;
        busy      <= 1'b1;
      end else if (busy) begin
        if (reduce) begin
          remainder <= remainder ^ (dsr << shift);
          quotient  <= quotient | (W'(1) << shift);
        end else begin
          busy    <= 1'b0;
          done    <= 1'b1;
          div_err <= dzero;
        end
      end
    end
  end

  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
  a_r3_degree_falls: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reduce |=> rzero || (rdeg < $past(rdeg)));
  a_r4_rem_below: assert property (@(posedge clk) disable iff (!rst_n)
    done && !div_err |-> rzero || (rdeg < ddeg));
  a_r6_err_quot: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |-> quotient == '0);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(quotient) && $stable(remainder) && $stable(div_err));
endmodule

// File: tb/gf2_poly_div_bench.sv
module gf2_poly_div_bench;
  localparam int W = 16;
  logic clk = 0, rst_n = 0, start = 0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic busy, done, div_err;
  logic [W-1:0] quotient, remainder;
  int checks = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;

  gf2_poly_div #(.W(W)) u_gf2_poly_div (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .div_err(div_err), .quotient(quotient), .remainder(remainder));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int deg(input logic [W-1:0] v);
    deg = -1;
    for (int i = 0; i < W; i++) if (v[i]) deg = i;
  endfunction

  function automatic logic [2*W-1:0] clmul(input logic [W-1:0] a, input logic [W-1:0] b);
    clmul = '0;
    for (int i = 0; i < W; i++) if (b[i]) clmul ^= ({{W{1'b0}}, a} << i);
  endfunction

  task automatic run(input logic [W-1:0] n, input logic [W-1:0] d, input bit inject, input string tag);
    logic [W-1:0] eq, er;
    int dd, cyc, tmo;
    eq = '0; er = n; dd = deg(d);
    if (dd >= 0)
      for (int i = W - 1; i >= 0; i--)
        if (er[i] && i >= dd) begin
          eq[i-dd] = 1'b1;
          er ^= d << (i - dd);
        end
    @(negedge clk);
    dividend = n; divisor = d; start = 1;
    @(negedge clk);
    start = 0;
    chk({tag, " R2 busy after start"}, busy, 1);
    cyc = 0; tmo = 0;
    while (!done && tmo < 100) begin
      if (busy) cyc++;
      if (inject && cyc == 3) begin
        dividend = 16'h0003; divisor = 16'h0002; start = 1;
      end else start = 0;
      @(negedge clk);
      tmo++;
    end
    start = 0;
    chk({tag, " R7 done seen"}, done, 1);
    chk({tag, " R7 busy low with done"}, busy, 0);
    chk({tag, " R5 busy cycles"}, cyc, $countones(eq) + 1);
    chk({tag, " R3 quotient"}, quotient, eq);
    chk({tag, " R4 remainder"}, remainder, er);
    chk({tag, " R6 err flag"}, div_err, (d == 0));
    if (d != 0) begin
      chk({tag, " R4 identity"}, clmul(quotient, d) ^ {{W{1'b0}}, remainder}, {{W{1'b0}}, n});
      chk({tag, " R4 rem degree"}, deg(remainder) < dd, 1);
    end
    @(negedge clk);
    chk({tag, " R7 done one cycle"}, done, 0);
    repeat (3) @(negedge clk);
    chk({tag, " R8 quotient held"}, quotient, eq);
    chk({tag, " R8 remainder held"}, remainder, er);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 err", div_err, 0);
    chk("R1 quotient", quotient, 0); chk("R1 remainder", remainder, 0);
    rst_n = 1;
    run(16'b1011_0110, 16'b101, 0, "basic");
    run(16'h0005, 16'h0013, 0, "R5 lower degree");
    run(16'h0000, 16'h0007, 0, "R5 zero dividend");
    run(16'h1234, 16'h0000, 0, "R6 zero divisor");
    run(16'hFFFF, 16'h0001, 0, "divide by one");
    run(16'h8011, 16'h8011, 0, "equal");
    run(16'hFFFF, 16'h0001, 1, "R9 start while busy");
    for (int k = 0; k < 40; k++) begin
      logic [W-1:0] a, b;
      a = W'($urandom);
      b = W'($urandom) >> ($urandom % W);
      if (b == 0) b = 16'h0003;
      run(a, b, 0, "random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule